// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point condition holds. It takes a 6-bit predicate code and the current 32-bit floating-point status word. From the sign, zero and not-a-number condition bits of that word it computes a true/false answer. It also returns a rewritten status word: the per-instruction exception byte is cleared, and the unordered-condition exception bit is raised when a predicate that is not IEEE-aware meets a NaN. The conditional branch, conditional set, conditional trap and decrement-and-branch instructions all share this one evaluator.

The predicate space splits into two families. Codes with bit 4 clear are IEEE-aware and never raise the unordered exception. Codes with bit 4 set give the same truth values, but they flag the unordered case. Bit 3 selects the negated form of a test: the low three bits are complemented to find the base test, and the answer is then inverted. Any code with bit 5 set is illegal.

The evaluation itself is combinational. All three results are captured in one output register, so every answer appears one clock after its inputs.

Top module: `fcond_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, cond_o, illegal_o and status_o all become 0.
- R2: Each output reflects the pred_i and status_i sampled at the previous rising edge. Between edges the outputs hold.
- R3: When pred_i[5] is 1, illegal_o is 1, cond_o is 0 and status_o equals status_i unchanged. When pred_i[5] is 0, illegal_o is 0.
- R4: When pred_i[5:3] is 000, the base test index t = pred_i[2:0] gives cond_o from status bits N = bit 27, Z = bit 26 and NAN = bit 24:
  - t=0: false.
  - t=1: Z.
  - t=2: NAN, Z and N all clear.
  - t=3: Z, or NAN and N both clear.
  - t=4: N set with NAN and Z clear.
  - t=5: Z, or N set with NAN clear.
  - t=6: NAN and Z both clear.
  - t=7: NAN clear.
- R5: When pred_i[3] is 1 and pred_i[5] is 0, cond_o is the inverse of base test ~pred_i[2:0].
- R6: pred_i[4] has no effect on cond_o. Codes that differ only in bit 4 give the same answer.
- R7: For a legal predicate, status_o[14:8] is 0 and every status bit outside 15:8 is copied from status_i.
- R8: For a legal predicate, status_o[15] is 1 exactly when pred_i[4] is 1 and status_i[24] (NAN) is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_i | input | 6 | Condition predicate code |
| status_i | input | 32 | Floating-point status word before the test |
| cond_o | output | 1 | Predicate result, registered |
| illegal_o | output | 1 | Predicate code is illegal, registered |
| status_o | output | 32 | Rewritten status word, registered |

## Verification
Apart from the output register, the block holds no state. A wrong decode or a wrong truth-table entry therefore shows up at the ports on the very next clock, for every status combination that reaches the faulty path. The bench walks all 64 predicate codes against all 16 combinations of the four condition bits. It does this under several exception-byte patterns, so each entry of each family, in plain and negated form, is seen within one cycle of being applied. The one-cycle latency and the hold between edges are checked directly, and so is the unchanged pass-through of status on illegal codes.

// File: rtl/fcond_pkg.sv
// Package: shared bit positions and decoded-predicate type for the
// floating-point condition evaluator. Assumes a 32-bit status word.
package fcond_pkg;

    localparam int PRED_W    = 6;
    localparam int BASE_W    = 3;
    localparam int N_BASE    = 1 << BASE_W;

    // status word field positions
    localparam int N_BIT     = 27;
    localparam int Z_BIT     = 26;
    localparam int INF_BIT   = 25;
    localparam int NAN_BIT   = 24;
    localparam int EXC_HI    = 15;
    localparam int EXC_LO    = 8;
    localparam int UNORD_BIT = 15;

    // predicate code field positions
    localparam int ILL_BIT   = 5;
    localparam int NOIEEE_BIT = 4;
    localparam int NEG_BIT   = 3;

    typedef struct packed {
        logic              illegal;
        logic              unaware;
        logic              negate;
        logic [BASE_W-1:0] base;
    } pred_dec_t;

endpackage

// File: rtl/fcond_decode.sv
// Module: fcond_decode
// Splits a predicate code into its illegal flag, IEEE-unaware flag,
// negation flag and base-test index. Purely combinational.
// Assumes the code is exactly PRED_W bits wide.
module fcond_decode
    import fcond_pkg::*;
(
    input  logic [PRED_W-1:0] pred,
    output pred_dec_t         dec
);

    // decode fields; the negated form complements the low index bits
    always_comb begin
        dec.illegal = pred[ILL_BIT];
        dec.unaware = pred[NOIEEE_BIT];
        dec.negate  = pred[NEG_BIT];
        dec.base    = pred[NEG_BIT] ? ~pred[BASE_W-1:0] : pred[BASE_W-1:0];
    end

endmodule

// File: rtl/fcond_test.sv
// Module: fcond_test
// Builds the truth vector of all eight base tests from N, Z and NAN,
// picks the selected entry and applies negation. Answers false for an
// illegal code. Purely combinational.
module fcond_test
    import fcond_pkg::*;
(
    input  pred_dec_t dec,
    input  logic      flag_n,
    input  logic      flag_z,
    input  logic      flag_nan,
    output logic      truth
);

    logic [N_BASE-1:0] tv;

    // class terms shared by the base tests
    logic is_gt, is_lt, is_eq;
    always_comb begin
        is_eq = flag_z;
        is_gt = !flag_nan && !flag_z && !flag_n;
        is_lt = !flag_nan && !flag_z &&  flag_n;
    end

    // one entry of the truth vector per base test
    for (genvar i = 0; i < N_BASE; i++) begin : g_base
        localparam logic [BASE_W-1:0] IDX = BASE_W'(i);
        always_comb begin
            // bit 0 = equal, bit 1 = greater, bit 2 = less; index 7 = ordered
            if (IDX == BASE_W'(N_BASE - 1))
                tv[i] = !flag_nan;
            else
                tv[i] = (IDX[0] && is_eq) || (IDX[1] && is_gt) || (IDX[2] && is_lt);
        end
    end

    // select, invert if negated, and force false when illegal
    always_comb begin
        truth = dec.illegal ? 1'b0 : (tv[dec.base] ^ dec.negate);
    end

endmodule

// File: rtl/fcond_status.sv
// Module: fcond_status
// Produces the rewritten status word: clears the exception byte and
// raises the unordered bit for an IEEE-unaware test that meets a NaN.
// An illegal code passes the status through untouched.
module fcond_status
    import fcond_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  pred_dec_t         dec,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out
);

    localparam logic [STAT_W-1:0] EXC_MASK =
        STAT_W'(((1 << (EXC_HI - EXC_LO + 1)) - 1) << EXC_LO);

    // compute the rewritten word
    always_comb begin
        stat_out = stat_in;
        if (!dec.illegal) begin
            stat_out = stat_in & ~EXC_MASK;
            if (dec.unaware && stat_in[NAN_BIT])
                stat_out[UNORD_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/fcond_unit.sv
// Module: fcond_unit (top)
// Floating-point condition predicate evaluator with a single registered
// output stage. Results appear one clock after the inputs.
// Synchronous active-low reset clears all outputs.
module fcond_unit
    import fcond_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        pred_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              cond_o,
    output logic              illegal_o,
    output logic [STAT_W-1:0] status_o
);

    pred_dec_t         dec;
    logic              truth;
    logic [STAT_W-1:0] stat_next;

    fcond_decode u_dec (
        .pred (pred_i),
        .dec  (dec)
    );

    fcond_test u_test (
        .dec      (dec),
        .flag_n   (status_i[N_BIT]),
        .flag_z   (status_i[Z_BIT]),
        .flag_nan (status_i[NAN_BIT]),
        .truth    (truth)
    );

    fcond_status #(.STAT_W(STAT_W)) u_stat (
        .dec      (dec),
        .stat_in  (status_i),
        .stat_out (stat_next)
    );

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_o    <= 1'b0;
            illegal_o <= 1'b0;
            status_o  <= '0;
        end else begin
            cond_o    <= truth;
            illegal_o <= dec.illegal;
            status_o  <= stat_next;
        end
    end

endmodule

// File: rtl/fcond_unit_chk.sv
// Module: fcond_unit_chk
// Property checker for fcond_unit; relates registered outputs to the
// inputs of the previous cycle. Bound into every fcond_unit instance.
module fcond_unit_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        pred_i,
    input logic [STAT_W-1:0] status_i,
    input logic              cond_o,
    input logic              illegal_o,
    input logic [STAT_W-1:0] status_o
);

    // armed: the previous edge was out of reset, so $past inputs are meaningful
    logic armed;
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (illegal_o == $past(pred_i[5])));                       // R3
    AST_ILLEGAL_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && illegal_o) |-> !cond_o);                                // R3
    AST_ILLEGAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && illegal_o) |-> (status_o == $past(status_i)));          // R3
    AST_ORDERED_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(pred_i) == 6'h07) |-> (cond_o == !$past(status_i[24]))); // R4
    AST_NEVER_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(pred_i[4:0]) == 5'h00) |-> !cond_o);              // R4
    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(pred_i) == 6'h0F) |-> cond_o);                    // R5
    AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !illegal_o) |-> (status_o[14:8] == 7'd0));              // R7
    AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (status_o[STAT_W-1:16] == $past(status_i[STAT_W-1:16]))); // R7
    AST_UNORD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !illegal_o) |->
            (status_o[15] == ($past(pred_i[4]) && $past(status_i[24])))); // R8

endmodule

bind fcond_unit fcond_unit_chk #(.STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pred_i    (pred_i),
    .status_i  (status_i),
    .cond_o    (cond_o),
    .illegal_o (illegal_o),
    .status_o  (status_o)
);

// File: tb/sim_fcond_unit.sv
// Bench for fcond_unit: exhaustive sweep of predicate codes against all
// condition-bit combinations, with a reference model written from the
// requirements.
module sim_fcond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pred = '0;
    logic [31:0] stat = '0;
    logic        cond_o, illegal_o;
    logic [31:0] status_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fcond_unit u0 (
        .clk(clk), .rst_n(rst_n), .pred_i(pred), .status_i(stat),
        .cond_o(cond_o), .illegal_o(illegal_o), .status_o(status_o)
    );

    // reference: relation classes drawn from N, Z, NAN
    function automatic void model(input logic [5:0] p, input logic [31:0] s,
                                  output logic c, output logic il,
                                  output logic [31:0] so);
        logic n, z, u, gt, lt, eq, b;
        int   t;
        n = s[27]; z = s[26]; u = s[24];
        eq = z; gt = !u && !z && !n; lt = !u && !z && n;
        t = p[3] ? (7 - int'(p[2:0])) : int'(p[2:0]);
        case (t)
            0: b = 1'b0;
            1: b = eq;
            2: b = gt;
            3: b = gt || eq;
            4: b = lt;
            5: b = lt || eq;
            6: b = gt || lt;
            default: b = !u;
        endcase
        il = p[5];
        c  = il ? 1'b0 : (p[3] ? !b : b);
        if (il) so = s;
        else begin
            so = s & 32'hFFFF_00FF;
            if (p[4] && u) so = so | 32'h0000_8000;
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pred=%02h stat=%08h actual=%08h expected=%08h",
                     tag, pred, stat, act, exp);
        end
    endtask

    task automatic apply_check(input logic [5:0] p, input logic [31:0] s);
        logic        ec, ei;
        logic [31:0] es;
        @(negedge clk);
        pred = p; stat = s;
        model(p, s, ec, ei, es);
        @(posedge clk); #2;
        chk("R3 illegal", {31'd0, illegal_o}, {31'd0, ei});
        if (p[5]) begin
            chk("R3 cond", {31'd0, cond_o}, {31'd0, ec});
            chk("R3 status", status_o, es);
        end else begin
            chk(p[3] ? "R5 cond" : "R4 cond", {31'd0, cond_o}, {31'd0, ec});
            chk("R7 status", status_o & 32'hFFFF_7FFF, es & 32'hFFFF_7FFF);
            chk("R8 unord", {31'd0, status_o[15]}, {31'd0, es[15]});
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] exc_pat [3];
        logic        c0, i0, c1, i1;
        logic [31:0] s0;
        exc_pat[0] = 8'hFF; exc_pat[1] = 8'h00; exc_pat[2] = 8'h5A;

        // R1: reset state with busy inputs
        pred = 6'h12; stat = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 cond", {31'd0, cond_o}, 32'd0);
        chk("R1 illegal", {31'd0, illegal_o}, 32'd0);
        chk("R1 status", status_o, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3/R4/R5/R7/R8: exhaustive sweep
        for (int e = 0; e < 3; e++)
            for (int p = 0; p < 64; p++)
                for (int f = 0; f < 16; f++)
                    apply_check(6'(p), {4'hA, 4'(f), 8'hC3, exc_pat[e], 8'h96});

        // R6: bit 4 leaves the answer unchanged
        for (int p = 0; p < 16; p++)
            for (int f = 0; f < 16; f++) begin
                s0 = {4'h0, 4'(f), 24'h00_FF_00};
                model(6'(p), s0, c0, i0, s0);
                s0 = {4'h0, 4'(f), 24'h00_FF_00};
                model(6'(p) | 6'h10, s0, c1, i1, s0);
                s0 = {4'h0, 4'(f), 24'h00_FF_00};
                apply_check(6'(p), s0);
                c0 = cond_o;
                apply_check(6'(p) | 6'h10, s0);
                chk("R6 aware vs unaware", {31'd0, cond_o}, {31'd0, c0});
            end

        // R2: outputs hold until the next edge, then update
        apply_check(6'h01, 32'h0400_0000);     // Z set, equal -> true
        @(negedge clk);
        pred = 6'h01; stat = 32'h0000_0000;    // now false
        #1;
        chk("R2 hold cond", {31'd0, cond_o}, 32'd1);
        chk("R2 hold status", status_o, 32'h0400_0000);
        @(posedge clk); #2;
        chk("R2 update cond", {31'd0, cond_o}, 32'd0);
        @(negedge clk);
        pred = 6'h21; stat = 32'h0400_FF00;
        #1;
        chk("R2 hold illegal", {31'd0, illegal_o}, 32'd0);
        @(posedge clk); #2;
        chk("R2 update illegal", {31'd0, illegal_o}, 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule